// File: doc/BRIEF.md
# Timer Compare-Match Event Unit

This block watches a free-running 16-bit timer and compares it, for equality, against a 16-bit compare value that software loads one byte at a time. A comparison strobe input marks each comparison slot. Several slots fall within each machine cycle, so a timer that steps once per slot at its fastest rate still cannot skip past the compare value. When the comparator is armed and an equality is newly seen, the unit emits a one-cycle match pulse. If the match function is also enabled, it sets a sticky event flag. The flag then raises an interrupt request when the channel's interrupt enable and the shared global enable are both on.

Software reaches the unit through a small byte-wide register port. Writing any byte below the top compare byte disarms the comparator, and writing the top byte re-arms it. A compare value that is only partly written therefore cannot produce a false match. Only hardware sets the flag, and only a software write clears it. When a clear and a new match meet on the same edge, the flag stays set.

Top module: `cmp_match_unit`

## Requirements
- R1: After reset, match_pulse, evt_flag and irq_req are 0, and all register bytes read 0.
- R2: With the comparator (mode bit 0) and match function (mode bit 1) on, a strobed comparison that finds tmr_val equal to the compare value, where the previous strobed comparison did not, sets match_pulse for one cycle and sets evt_flag. Both take effect at that same clock edge.
- R3: While mode bit 0 is 0, no comparison takes place, so neither match_pulse nor evt_flag is set.
- R4: With mode bit 0 on and mode bit 1 off, a match raises match_pulse but leaves evt_flag unchanged.
- R5: An equal timer value on a cycle without cmp_tick has no effect.
- R6: While equality holds over consecutive strobes, only the first strobe produces a match. A strobe that sees inequality re-arms the detection.
- R7: irq_req equals evt_flag AND mode bit 2 AND glb_irq_en, with no register stage in between.
- R8: evt_flag stays set until a write to address 3 with wdata bit 0 = 1. A write to address 3 with bit 0 = 0 has no effect.
- R9: If a clear write and a flag-setting match fall on the same edge, evt_flag remains 1.
- R10: A write to address 0 (low compare byte) clears mode bit 0. A write to address 1 (high compare byte) sets it.
- R11: The register map is: address 0 holds the low compare byte, address 1 the high compare byte, and address 2 the mode bits [2:0]. Address 3 reads evt_flag in bit 0. Reads are combinational on reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_val | input | 16 | Current timer value |
| cmp_tick | input | 1 | Comparison slot strobe |
| glb_irq_en | input | 1 | Global enable of the shared interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| match_pulse | output | 1 | One-cycle match indication |
| evt_flag | output | 1 | Sticky event flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The strobed comparison, the flag update and register writes all land at the first rising edge after the stimulus. The bench drives on the falling edge and checks match_pulse, evt_flag and the register contents 1 ns after the next rising edge. irq_req and reg_rdata are combinational, so they are checked in that same window, directly after their inputs change. Held-equality and re-arm cases come from a vector table with one strobe per row. Collisions, disarming and enable gating are covered by directed steps.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  localparam int MODE_CMP_BIT = 0;
  localparam int MODE_MAT_BIT = 1;
  localparam int MODE_IRQ_BIT = 2;
  localparam int STAT_FLAG_BIT = 0;

  typedef struct packed {
    logic irq_en;
    logic mat_en;
    logic cmp_en;
  } mode_t;
endpackage

// File: rtl/cmu_regs.sv
module cmu_regs
  import cmu_pkg::*;
#(
  parameter int TW = 16,
  parameter int BW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  input  logic          flag,
  output logic [TW-1:0] cmp_val,
  output mode_t         mode,
  output logic          clr_req,
  output logic [BW-1:0] rdata
);
  localparam int NB = TW / BW;
  localparam logic [AW-1:0] MODE_ADDR = AW'(NB);
  localparam logic [AW-1:0] STAT_ADDR = AW'(NB + 1);
  localparam logic [AW-1:0] TOP_ADDR  = AW'(NB - 1);

  logic [NB-1:0][BW-1:0] byte_q;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         byte_q[i] <= '0;
      else if (we && addr == AW'(i))      byte_q[i] <= wdata;
    end
  end

  assign cmp_val = byte_q;

  // Byte-wise update: lower bytes disarm, top byte re-arms
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (we) begin
      if (addr == MODE_ADDR) begin
        mode.cmp_en <= wdata[MODE_CMP_BIT];
        mode.mat_en <= wdata[MODE_MAT_BIT];
        mode.irq_en <= wdata[MODE_IRQ_BIT];
      end else if (addr == TOP_ADDR) begin
        mode.cmp_en <= 1'b1;
      end else if (addr < TOP_ADDR) begin
        mode.cmp_en <= 1'b0;
      end
    end
  end

  assign clr_req = we && (addr == STAT_ADDR) && wdata[STAT_FLAG_BIT];

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NB; i++) begin
      if (addr == AW'(i)) rdata = byte_q[i];
    end
    if (addr == MODE_ADDR) begin
      rdata[MODE_CMP_BIT] = mode.cmp_en;
      rdata[MODE_MAT_BIT] = mode.mat_en;
      rdata[MODE_IRQ_BIT] = mode.irq_en;
    end
    if (addr == STAT_ADDR) rdata[STAT_FLAG_BIT] = flag;
  end
endmodule

// File: rtl/cmu_compare.sv
module cmu_compare #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmp_en,
  input  logic [TW-1:0] tmr,
  input  logic [TW-1:0] cmp_val,
  output logic          hit,
  output logic          pulse_q
);
  logic eq;
  logic eq_q;

  assign eq  = (tmr == cmp_val);
  assign hit = tick && cmp_en && eq && !eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit;
      if (!cmp_en)   eq_q <= 1'b0;
      else if (tick) eq_q <= eq;
    end
  end
endmodule

// File: rtl/cmu_flag.sv
module cmu_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic mat_en,
  input  logic clr,
  input  logic irq_en,
  input  logic glb_en,
  output logic flag,
  output logic irq
);
  // Set wins over clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (hit && mat_en) || (flag && !clr);
  end

  assign irq = flag && irq_en && glb_en;
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
  import cmu_pkg::*;
#(
  parameter int TW = 16,
  parameter int BW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tmr_val,
  input  logic          cmp_tick,
  input  logic          glb_irq_en,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [BW-1:0] reg_wdata,
  output logic [BW-1:0] reg_rdata,
  output logic          match_pulse,
  output logic          evt_flag,
  output logic          irq_req
);
  logic [TW-1:0] cmp_val;
  mode_t         mode;
  logic          cmp_en;
  logic          clr_req;
  logic          hit;

  assign cmp_en = mode.cmp_en;

  cmu_regs #(.TW(TW), .BW(BW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .flag(evt_flag), .cmp_val(cmp_val), .mode(mode), .clr_req(clr_req),
    .rdata(reg_rdata)
  );

  cmu_compare #(.TW(TW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(cmp_tick), .cmp_en(cmp_en), .tmr(tmr_val),
    .cmp_val(cmp_val), .hit(hit), .pulse_q(match_pulse)
  );

  cmu_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .mat_en(mode.mat_en), .clr(clr_req),
    .irq_en(mode.irq_en), .glb_en(glb_irq_en), .flag(evt_flag), .irq(irq_req)
  );
endmodule

// File: rtl/cmu_chk.sv
module cmu_chk #(
  parameter int TW = 16,
  parameter int BW = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] tmr_val,
  input logic          cmp_tick,
  input logic          glb_irq_en,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [BW-1:0] reg_wdata,
  input logic          match_pulse,
  input logic          evt_flag,
  input logic          irq_req,
  input logic [TW-1:0] cmp_val,
  input logic          cmp_en
);
  localparam int NB = TW / BW;
  localparam logic [AW-1:0] STAT_ADDR = AW'(NB + 1);
  localparam logic [AW-1:0] TOP_ADDR  = AW'(NB - 1);

  AST_PULSE_NEEDS_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> ($past(tmr_val) == $past(cmp_val)));  // R2
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(cmp_en));  // R3
  AST_FLAG_RISE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> match_pulse);  // R4
  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(cmp_tick));  // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (evt_flag && glb_irq_en));  // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !(reg_we && reg_addr == STAT_ADDR && reg_wdata[0])) |=> evt_flag);  // R8
  AST_LOW_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr < TOP_ADDR) |=> !cmp_en);  // R10
  AST_TOP_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == TOP_ADDR) |=> cmp_en);  // R10
endmodule

bind cmp_match_unit cmu_chk #(.TW(TW), .BW(BW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .cmp_tick(cmp_tick),
  .glb_irq_en(glb_irq_en), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .match_pulse(match_pulse), .evt_flag(evt_flag),
  .irq_req(irq_req), .cmp_val(cmp_val), .cmp_en(cmp_en)
);

// File: tb/cmp_match_unit_tb.sv
`timescale 1ns/1ps
module cmp_match_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr_val = '0;
  logic        cmp_tick = 1'b0;
  logic        glb_irq_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        match_pulse, evt_flag, irq_req;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cmp_match_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .cmp_tick(cmp_tick),
    .glb_irq_en(glb_irq_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .match_pulse(match_pulse),
    .evt_flag(evt_flag), .irq_req(irq_req)
  );

  // {tmr_val, tick, expected match_pulse, expected evt_flag}; compare = 0x1234
  localparam logic [18:0] VEC [0:7] = '{
    {16'h1233, 1'b1, 1'b0, 1'b0},
    {16'h1234, 1'b0, 1'b0, 1'b0},
    {16'h1234, 1'b1, 1'b1, 1'b1},
    {16'h1234, 1'b1, 1'b0, 1'b1},
    {16'h1234, 1'b1, 1'b0, 1'b1},
    {16'h1235, 1'b1, 1'b0, 1'b1},
    {16'h1234, 1'b1, 1'b1, 1'b1},
    {16'h1236, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [15:0] t, input logic tk, input logic we,
                     input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    tmr_val = t; cmp_tick = tk; reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_we = 1'b0; cmp_tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 match", match_pulse, 0);
    chk("R1 flag", evt_flag, 0);
    chk("R1 irq", irq_req, 0);
    rst_n = 1'b1;
    cyc(16'h0, 0, 0, 2'd2, 8'h00);
    chk("R1 mode read", reg_rdata, 8'h00);
    cyc(16'h0, 0, 0, 2'd0, 8'h00);
    chk("R1 low read", reg_rdata, 8'h00);

    glb_irq_en = 1'b1;
    cyc(16'h0, 0, 1, 2'd0, 8'h34);
    cyc(16'h0, 0, 1, 2'd1, 8'h12);
    cyc(16'h0, 0, 1, 2'd2, 8'h07);

    for (int i = 0; i < 8; i++) begin
      cyc(VEC[i][18:3], VEC[i][2], 0, 2'd3, 8'h00);
      chk("R2/R5/R6 match", match_pulse, int'(VEC[i][1]));
      chk("R2/R6 flag", evt_flag, int'(VEC[i][0]));
    end
    chk("R7 irq with both enables", irq_req, 1);

    // R8: clear with bit0 = 0 has no effect, bit0 = 1 clears
    cyc(16'h0, 0, 1, 2'd3, 8'hFE);
    chk("R8 flag after bit0=0 write", evt_flag, 1);
    cyc(16'h0, 0, 1, 2'd3, 8'h01);
    chk("R8 flag after clear", evt_flag, 0);
    chk("R8 irq after clear", irq_req, 0);

    // R7: gating of irq_req
    cyc(16'h0, 0, 1, 2'd2, 8'h03);
    cyc(16'h0, 1, 0, 2'd3, 8'h00);
    cyc(16'h1234, 1, 0, 2'd3, 8'h00);
    chk("R7 flag set", evt_flag, 1);
    chk("R7 irq off when irq_en=0", irq_req, 0);
    cyc(16'h0, 0, 1, 2'd2, 8'h07);
    chk("R7 irq on", irq_req, 1);
    @(negedge clk); glb_irq_en = 1'b0; #1;
    chk("R7 irq off when global off", irq_req, 0);
    glb_irq_en = 1'b1;
    cyc(16'h0, 0, 1, 2'd3, 8'h01);

    // R4: comparator only
    cyc(16'h0, 0, 1, 2'd2, 8'h01);
    cyc(16'h0, 1, 0, 2'd3, 8'h00);
    cyc(16'h1234, 1, 0, 2'd3, 8'h00);
    chk("R4 match without match-enable", match_pulse, 1);
    chk("R4 flag stays clear", evt_flag, 0);

    // R3: comparator off
    cyc(16'h0, 0, 1, 2'd2, 8'h06);
    cyc(16'h0, 1, 0, 2'd3, 8'h00);
    cyc(16'h1234, 1, 0, 2'd3, 8'h00);
    chk("R3 no match when disabled", match_pulse, 0);
    chk("R3 no flag when disabled", evt_flag, 0);

    // R9: clear write and match on the same edge
    cyc(16'h0, 0, 1, 2'd2, 8'h07);
    cyc(16'h0, 1, 0, 2'd3, 8'h00);
    cyc(16'h1234, 1, 1, 2'd3, 8'h01);
    chk("R9 match on collision", match_pulse, 1);
    chk("R9 flag kept on collision", evt_flag, 1);
    cyc(16'h0, 0, 1, 2'd3, 8'h01);

    // R10: byte-wise update disarms then re-arms
    cyc(16'h0, 0, 1, 2'd0, 8'h00);
    cyc(16'h0, 0, 0, 2'd2, 8'h00);
    chk("R10 mode bit0 after low write", reg_rdata[0], 0);
    cyc(16'h1201, 1, 0, 2'd2, 8'h00);
    cyc(16'h1200, 1, 0, 2'd2, 8'h00);
    chk("R10 no match while disarmed", match_pulse, 0);
    cyc(16'h0, 0, 1, 2'd1, 8'h12);
    cyc(16'h0, 0, 0, 2'd2, 8'h00);
    chk("R10 mode bit0 after high write", reg_rdata[0], 1);
    cyc(16'h1201, 1, 0, 2'd2, 8'h00);
    cyc(16'h1200, 1, 0, 2'd2, 8'h00);
    chk("R10 match after re-arm", match_pulse, 1);

    // R11: register map readback
    cyc(16'h0, 0, 0, 2'd0, 8'h00);
    chk("R11 low byte", reg_rdata, 8'h00);
    cyc(16'h0, 0, 0, 2'd1, 8'h00);
    chk("R11 high byte", reg_rdata, 8'h12);
    cyc(16'h0, 0, 0, 2'd2, 8'h00);
    chk("R11 mode", reg_rdata, 8'h07);
    cyc(16'h0, 0, 0, 2'd3, 8'h00);
    chk("R11 status", reg_rdata, 8'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule